// File: doc/BRIEF.md
# Strobed ROM Address Loader

This block is the command-side data path of a byte-wide ROM that a host reaches over one 8-bit data bus and a handful of asynchronous control lines: an active-low chip select, an active-low write strobe, an active-low read strobe and a 3-bit register select. When the top select bit is 0, each write strobe deposits one byte of a 20-bit address counter, least significant byte first, through an internal byte pointer. Each read strobe presents the ROM byte at the counter on the bus and then steps the counter by one. The host can therefore stream a block of data after a single address load, or reload only the low one or two bytes to jump within a page or a 64 KB block.

All host lines, the select and the data bus pass through the same synchronizer chain on a fast system clock. Strobe edges are detected after that chain. Accesses with the top select bit at 1 belong to expansion registers outside this block. They leave the pointer and the counter alone, so an address load interrupted by such accesses resumes where it stopped. The data bus is returned as a separate output value and an output-enable flag for the pad.

The ROM is a parameterised internal table. Entry i holds (i*37 + SEED) mod 256, where SEED is a parameter. An address A selects entry A[7:0] ^ A[15:8] ^ {4'b0, A[19:16]}, so every address bit affects the byte read.

Top module: `strom_loader`

## Requirements
- R1: After reset the address counter is 0x00000, the byte pointer selects the low byte and data_oe is 0.
- R2: With rs[2]=0, the first write after a pointer clear loads address bits 7:0, the second loads bits 15:8, and the third loads bits 19:16 from data bits 3:0, ignoring data bits 7:4. The data is taken at the rising edge of we_n, and the pointer steps at the falling edge of we_n.
- R3: A load of only the low byte, or of only the low two bytes, leaves the higher address bits unchanged.
- R4: Once the pointer reaches the top byte it stays there, and each further write replaces bits 19:16.
- R5: While a ROM read is active (ce_n=0, rs[2]=0, oe_n=0, we_n=1), data_oe=1 and data_o equals the table byte at the current address, computed as stated above.
- R6: Each rising edge of oe_n during a ROM access advances the address by one, and 0xFFFFF wraps to 0x00000.
- R7: An active ROM read clears the pointer, so the next write loads bits 7:0.
- R8: While ce_n=1 the pointer is held clear, strobes change neither the address nor the pointer, and data_oe=0. The stored address is kept.
- R9: Reads and writes with rs[2]=1 neither advance nor clear the pointer, leave the address unchanged and never raise data_oe. With rs[2]=0, rs[1:0] have no effect.
- R10: data_oe is 1 only when ce_n=0, oe_n=0, we_n=1 and rs[2]=0, as seen through the synchronizer. With both strobes low the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all host lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low read strobe |
| rs | input | 3 | Register select; bit 2 = 0 targets the address counter or ROM data |
| data_i | input | 8 | Host-to-device data bus value |
| data_o | output | 8 | Device-to-host data bus value (0 when not driving) |
| data_oe | output | 1 | Output enable for the data bus pad |

## Verification
A wrong pointer position is invisible until the next write. It then surfaces as a wrong table byte on the first read that follows, because each address byte lands in the wrong bit field and the read hash mixes every field. A counter that fails to step, or steps at the wrong moment, shows up on the very next read strobe as a repeated or skipped byte. A leak of expansion accesses or deselect periods into the pointer shows up at the first ROM read after an interrupted load. Bus-enable errors appear at the ports two clocks after the offending strobe combination.

// File: rtl/strom_pkg.sv
package strom_pkg;

   // multiplier used to fill the internal table
   localparam int unsigned TBL_MULT = 37;

   // host lines as carried through the synchronizer
   typedef struct packed {
      logic       ce_n;
      logic       we_n;
      logic       oe_n;
      logic [2:0] rs;
      logic [7:0] data;
   } host_t;

   localparam host_t HOST_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, rs: 3'b000, data: 8'h00};

   function automatic logic [7:0] tbl_byte(input int unsigned idx, input logic [7:0] seed);
      int unsigned v;
      v = idx * TBL_MULT + int'(seed);
      return v[7:0];
   endfunction

endpackage

// File: rtl/strom_sync.sv
module strom_sync #(
   parameter int          W      = 8,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("strom_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= RST;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[s] <= RST;
            else        st[s] <= st[s-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/strom_bptr.sv
module strom_bptr #(
   parameter int NSLOT = 3,
   localparam int PTR_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [PTR_W-1:0] wsel
);

   localparam logic [PTR_W-1:0] TOP = PTR_W'(NSLOT - 1);

   logic [PTR_W-1:0] ptr;

   if (NSLOT == 1) begin : g_single
      logic unused_bptr;
      assign unused_bptr = clr ^ adv;
      assign ptr  = '0;
      assign wsel = '0;
   end else begin : g_multi
      // the slot is latched at the falling strobe edge; data lands at the rise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr  <= '0;
            wsel <= '0;
         end else begin
            if (adv) wsel <= ptr;
            if (clr)                     ptr <= '0;
            else if (adv && ptr != TOP)  ptr <= ptr + 1'b1;
         end
      end

      // R7 R8
      ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> ptr == '0);

      // R4
      ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ptr <= TOP);

      // R4
      ptr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (adv && !clr && ptr == TOP) |=> ptr == TOP);

      // R2
      ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (adv && !clr && ptr != TOP) |=> ptr == $past(ptr) + 1'b1);

      // R9
      ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!adv && !clr) |=> $stable(ptr));
   end

endmodule

// File: rtl/strom_actr.sv
module strom_actr #(
   parameter int ADDR_W = 20,
   localparam int NSLOT = (ADDR_W + 7) / 8,
   localparam int PTR_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [PTR_W-1:0]  wsel,
   input  logic [7:0]        wdata,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] ld_mask;
   logic [ADDR_W-1:0] ld_val;
   logic [ADDR_W-1:0] addr_nx;

   // one byte lane per slot; the last lane may be narrower
   for (genvar k = 0; k < NSLOT; k++) begin : g_lane
      localparam int SW = (ADDR_W - 8*k > 8) ? 8 : (ADDR_W - 8*k);
      assign ld_mask[8*k +: SW] = {SW{ld && (wsel == PTR_W'(k))}};
      assign ld_val [8*k +: SW] = wdata[SW-1:0];
   end

   always_comb begin
      if (inc) addr_nx = addr + 1'b1;
      else     addr_nx = (addr & ~ld_mask) | (ld_val & ld_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr <= '0;
      else        addr <= addr_nx;
   end

   // R6
   addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && addr == '1) |=> addr == '0);

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && addr != '1) |=> addr == $past(addr) + 1'b1);

   // R3 R8 R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !ld) |=> $stable(addr));

endmodule

// File: rtl/strom_array.sv
module strom_array
   import strom_pkg::*;
#(
   parameter int         ADDR_W = 20,
   parameter int         IDX_W  = 8,
   parameter logic [7:0] SEED   = 8'h00,
   localparam int        DEPTH  = 1 << IDX_W,
   localparam int        NSLOT  = (ADDR_W + 7) / 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [7:0]        rdata
);

   logic [7:0]       mem [DEPTH];
   logic [7:0]       fold;
   logic [IDX_W-1:0] idx;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      assign mem[i] = tbl_byte(i, SEED);
   end

   // every address byte is folded into the index
   always_comb begin
      fold = '0;
      for (int k = 0; k < NSLOT; k++) begin
         fold = fold ^ 8'(addr >> (8*k));
      end
   end

   assign idx   = fold[IDX_W-1:0];
   assign rdata = mem[idx];

   if (IDX_W == 8) begin : g_full
   end else begin : g_part
      logic unused_fold;
      assign unused_fold = ^fold[7:IDX_W];
   end

endmodule

// File: rtl/strom_loader.sv
module strom_loader
   import strom_pkg::*;
#(
   parameter int         ADDR_W      = 20,
   parameter int         IDX_W       = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] SEED        = 8'h00,
   localparam int        NSLOT       = (ADDR_W + 7) / 8,
   localparam int        PTR_W       = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce_n,
   input  logic       we_n,
   input  logic       oe_n,
   input  logic [2:0] rs,
   input  logic [7:0] data_i,
   output logic [7:0] data_o,
   output logic       data_oe
);

   if (ADDR_W < 9 || ADDR_W > 32) begin : g_bad_addr
      $error("strom_loader: ADDR_W out of range 9..32");
   end
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("strom_loader: IDX_W out of range 1..8");
   end

   host_t raw;
   host_t syn;
   logic  prv_we_n, prv_oe_n;

   assign raw = {ce_n, we_n, oe_n, rs, data_i};

   strom_sync #(
      .W      ($bits(host_t)),
      .STAGES (SYNC_STAGES),
      .RST    (HOST_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv_we_n <= 1'b1;
         prv_oe_n <= 1'b1;
      end else begin
         prv_we_n <= syn.we_n;
         prv_oe_n <= syn.oe_n;
      end
   end

   logic unused_rs;
   assign unused_rs = ^syn.rs[1:0];

   logic rom_acc, we_fall, we_rise, oe_rise, rd_active, ptr_clr;
   logic adv, ld, inc;

   assign rom_acc   = !syn.ce_n && !syn.rs[2];
   assign we_fall   =  prv_we_n && !syn.we_n;
   assign we_rise   = !prv_we_n &&  syn.we_n;
   assign oe_rise   = !prv_oe_n &&  syn.oe_n;
   assign rd_active = rom_acc && !syn.oe_n;
   assign ptr_clr   = syn.ce_n || rd_active;
   assign adv       = rom_acc && we_fall;
   assign ld        = rom_acc && we_rise;
   assign inc       = rom_acc && oe_rise;

   logic [PTR_W-1:0]  wsel;
   logic [ADDR_W-1:0] addr;
   logic [7:0]        rom_byte;

   strom_bptr #(.NSLOT(NSLOT)) u_bptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ptr_clr),
      .adv   (adv),
      .wsel  (wsel)
   );

   strom_actr #(.ADDR_W(ADDR_W)) u_actr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld),
      .wsel  (wsel),
      .wdata (syn.data),
      .inc   (inc),
      .addr  (addr)
   );

   strom_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEED(SEED)) u_array (
      .addr  (addr),
      .rdata (rom_byte)
   );

   assign data_oe = rd_active && syn.we_n;
   assign data_o  = data_oe ? rom_byte : 8'h00;

   if (SYNC_STAGES == 2) begin : g_oe_chk
      // R10
      oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         data_oe |-> (!$past(ce_n, 2) && !$past(oe_n, 2) && $past(we_n, 2) && !$past(rs[2], 2)));
   end

   // R8
   desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      syn.ce_n |-> !data_oe);

endmodule

// File: tb/tb_strom_loader.sv
module tb_strom_loader;

   localparam logic [7:0] SEED = 8'h5A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b1;
   logic       we_n = 1'b1;
   logic       oe_n = 1'b1;
   logic [2:0] rs = 3'b000;
   logic [7:0] data_i = 8'h00;
   logic [7:0] data_o;
   logic       data_oe;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #4 clk = ~clk;

   strom_loader #(.SEED(SEED)) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_n),
      .we_n    (we_n),
      .oe_n    (oe_n),
      .rs      (rs),
      .data_i  (data_i),
      .data_o  (data_o),
      .data_oe (data_oe)
   );

   // expected table byte for a 20-bit address, from the stated rule
   function automatic logic [7:0] exp_byte(input logic [19:0] a);
      logic [7:0] i;
      int unsigned v;
      i = a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]};
      v = int'(i) * 37 + int'(SEED);
      return v[7:0];
   endfunction

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                  req, act[8], act[7:0], exp[8], exp[7:0]);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_wr(input logic [2:0] sel, input logic [7:0] d);
      rs = sel; data_i = d;
      idle(3);
      we_n = 1'b0;
      idle(4);
      // R10: a write strobe never drives the bus
      check("R10", {data_oe, data_o}, 9'h000);
      we_n = 1'b1;
      idle(4);
   endtask

   task automatic do_rd(input string req, input logic [2:0] sel, input logic exp_oe,
                        input logic [19:0] ea);
      rs = sel;
      idle(3);
      oe_n = 1'b0;
      idle(4);
      check(req, {data_oe, data_o}, exp_oe ? {1'b1, exp_byte(ea)} : 9'h000);
      oe_n = 1'b1;
      idle(4);
   endtask

   typedef struct packed {
      logic [1:0]  op;   // 0 write, 1 read, 2 deselect pulse, 3 strobes while deselected
      logic [2:0]  rs;
      logic [7:0]  din;
      logic [19:0] ea;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 3'b000, 8'h34, 20'h00000},  // R2 low byte
      '{2'd0, 3'b011, 8'h56, 20'h00000},  // R2 R9 lower select ignored
      '{2'd0, 3'b010, 8'hF7, 20'h00000},  // R2 only low nibble used
      '{2'd1, 3'b000, 8'h00, 20'h75634},  // R5
      '{2'd1, 3'b000, 8'h00, 20'h75635},  // R6 sequential
      '{2'd0, 3'b000, 8'h3D, 20'h00000},  // R7 read cleared pointer
      '{2'd1, 3'b000, 8'h00, 20'h7563D},  // R3 page reload
      '{2'd0, 3'b000, 8'h10, 20'h00000},
      '{2'd0, 3'b100, 8'hAA, 20'h00000},  // R9 expansion write
      '{2'd1, 3'b101, 8'h00, 20'h00000},  // R9 expansion read
      '{2'd0, 3'b000, 8'h22, 20'h00000},  // R9 resumes at middle byte
      '{2'd0, 3'b001, 8'h01, 20'h00000},
      '{2'd0, 3'b000, 8'h0E, 20'h00000},  // R4 saturated top byte
      '{2'd1, 3'b000, 8'h00, 20'hE2210},
      '{2'd2, 3'b000, 8'h00, 20'h00000},  // R8 deselect clears pointer
      '{2'd0, 3'b000, 8'hFF, 20'h00000},
      '{2'd1, 3'b000, 8'h00, 20'hE22FF},  // R8 address kept across deselect
      '{2'd1, 3'b000, 8'h00, 20'hE2300},  // R6 carry into middle byte
      '{2'd0, 3'b000, 8'hFF, 20'h00000},
      '{2'd0, 3'b000, 8'hFF, 20'h00000},
      '{2'd0, 3'b000, 8'h0F, 20'h00000},
      '{2'd1, 3'b000, 8'h00, 20'hFFFFF},
      '{2'd1, 3'b000, 8'h00, 20'h00000},  // R6 wrap
      '{2'd3, 3'b000, 8'h55, 20'h00000},  // R8 strobes ignored
      '{2'd1, 3'b000, 8'h00, 20'h00001}
   };

   initial begin
      idle(3);
      // R1: reset state
      check("R1", {data_oe, data_o}, 9'h000);
      rst_n = 1'b1;
      idle(2);
      ce_n = 1'b0;
      idle(3);
      check("R1", {data_oe, data_o}, 9'h000);
      do_rd("R1", 3'b000, 1'b1, 20'h00000);

      for (int i = 0; i < NV; i++) begin
         case (VEC[i].op)
            2'd0: do_wr(VEC[i].rs, VEC[i].din);
            2'd1: do_rd(VEC[i].rs[2] ? "R9" : "R5", VEC[i].rs, !VEC[i].rs[2], VEC[i].ea);
            2'd2: begin
               ce_n = 1'b1; idle(4);
               check("R8", {data_oe, data_o}, 9'h000);
               ce_n = 1'b0; idle(4);
            end
            default: begin
               ce_n = 1'b1; idle(3);
               do_wr(VEC[i].rs, VEC[i].din);
               do_rd("R8", VEC[i].rs, 1'b0, 20'h00000);
               ce_n = 1'b0; idle(4);
            end
         endcase
      end

      // R10: both strobes low leaves the bus undriven; address now 0x00002
      rs = 3'b000; data_i = 8'h40;
      idle(3);
      we_n = 1'b0; idle(4);
      oe_n = 1'b0; idle(4);
      check("R10", {data_oe, data_o}, 9'h000);
      oe_n = 1'b1; idle(4);
      we_n = 1'b1; idle(4);
      // R2: slot latched at write fall was the low byte: 0x00003 -> 0x00040
      do_rd("R2", 3'b000, 1'b1, 20'h00040);
      // R6: next sequential byte
      do_rd("R6", 3'b000, 1'b1, 20'h00041);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule